// File: doc/BRIEF.md
# Ferroelectric Pseudo-SRAM Host Controller

This block is a bus master on the host side of a 256K x 16 nonvolatile pseudo-SRAM. It takes one single-word read or write request at a time. Each request carries an 18-bit word address, 16 bits of write data, a two-bit lane select and a direction. The block turns the request into a correctly spaced sequence on the memory's control pins: address, chip enable, write enable, output enable and active-low byte enables. For reads it returns the captured word together with a one-cycle valid pulse.

The memory needs more than a plain SRAM does. Chip enable has a minimum low time. Every access is followed by a precharge interval with chip enable high. A complete access has a minimum fall-to-fall period. The address and byte enables must be settled before chip enable falls and must not move while it is low. Writes are strobed by write enable, which rises while chip enable is still low. All of these intervals are parameters counted in system-clock cycles.

The data pins are split into an output word, a drive enable and an input word, so the pad ring can build the bidirectional bus. Output enable and the drive enable are never active together. The parameters must satisfy WP_CYC >= 1 and ACT_CYC - WP_CYC >= 1.

Top module: `fram_host_ctrl`

## Requirements
- R1: While reset is held and just after it, req_ready is 1. Chip enable, write enable, output enable and both byte enables are high (inactive). mem_dq_drive is 0 and rd_valid is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. From the accepting edge until precharge ends, req_ready is 0, and any req_valid seen in that time has no effect on the memory.
- R3: For every access, chip enable stays low for exactly ACT_CYC+1 cycles. In a read, output enable is low for that whole window. rd_valid is a single-cycle pulse in the first cycle after chip enable rises, and rd_data carries the word sampled at the end of the last low cycle.
- R4: req_bmask bit 0 selects bits 7:0 and bit 1 selects bits 15:8. For the whole access, mem_ben_n bit i is the inverse of mask bit i. On a read, rd_data bits of unselected lanes are 0. A mask of 00 reads as 0000.
- R5: In a write, write enable is low for exactly WP_CYC cycles. Its last low cycle is the second-to-last chip-enable-low cycle, so write enable rises while chip enable is still low. Output enable stays high and mem_dq_drive stays 1 while chip enable is low.
- R6: Between accesses, chip enable stays high for at least PRE_CYC cycles. Two successive chip-enable falls are at least CYC_CYC cycles apart. When requests arrive back to back, the high time is max(PRE_CYC, CYC_CYC-ACT_CYC-3)+2 cycles.
- R7: mem_addr and mem_ben_n take their new values in the cycle before chip enable falls and do not change while chip enable is low.
- R8: Output enable is never low in a cycle where mem_dq_drive is 1.
- R9: A write never produces a rd_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_bmask | input | DATA_W/8 | Lane select, bit i enables bits 8i+7:8i |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | DATA_W | Read word, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ben_n | output | DATA_W/8 | Byte enables, active low, bit 0 lower byte |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_drive | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
The bench models the memory so that unselected lanes return junk. A design that failed to mask lanes, or that drove the wrong byte-enable pin, would therefore return wrong upper or lower bytes after partial writes. It measures chip-enable low and high runs, the fall-to-fall period and the write-strobe width on back-to-back traffic. This catches precharge or cycle-time floors that are off by one, and a write strobe that rises with or after chip enable. A stray request injected mid-access would corrupt an address that is later read back if the busy gating leaked. Monitors also catch addresses moving under chip enable, output enable overlapping the data drive, and read pulses that are doubled, mistimed or raised by writes.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_SETUP,
        S_ACTIVE,
        S_PRE
    } fhc_state_e;
endpackage

// File: rtl/fhc_seq.sv
// Access sequencer: owns the state, the interval counter and every strobe.
module fhc_seq
    import fhc_pkg::*;
#(
    parameter int ACT_CYC = 15,
    parameter int WP_CYC  = 4,
    parameter int PRE_CYC = 15,
    parameter int CYC_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic ready,
    output logic accept,
    output logic cap_en,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic dq_drive
);
    // idle + setup cycles add 2 to the high time; active lasts ACT_CYC+1
    localparam int PRE_FLOOR = CYC_CYC - ACT_CYC - 3;
    localparam int PRE_LEN   = (PRE_CYC > PRE_FLOOR) ? PRE_CYC : PRE_FLOOR;
    localparam int CNT_MAX   = (ACT_CYC > PRE_LEN) ? ACT_CYC : PRE_LEN;
    localparam int CW        = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] ACT_LAST = CW'(ACT_CYC);
    localparam logic [CW-1:0] WE_FIRST = CW'(ACT_CYC - WP_CYC);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_LEN - 1);

    typedef struct packed {
        fhc_state_e    st;
        logic [CW-1:0] cnt;
        logic          wr;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic          drv;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: S_IDLE, cnt: '0, wr: 1'b0, ce_n: 1'b1,
                                 we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    seq_t s_d, s_q;
    logic [CW-1:0] nxt_cnt;

    assign ready   = (s_q.st == S_IDLE);
    assign accept  = ready && req_valid;
    assign cap_en  = (s_q.st == S_ACTIVE) && (s_q.cnt == ACT_LAST) && !s_q.wr;
    assign nxt_cnt = s_q.cnt + 1'b1;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    s_d.st  = S_SETUP;
                    s_d.wr  = req_write;
                    s_d.drv = req_write;
                end
            end
            S_SETUP: begin
                s_d.st   = S_ACTIVE;
                s_d.cnt  = '0;
                s_d.ce_n = 1'b0;
                s_d.oe_n = s_q.wr;
            end
            S_ACTIVE: begin
                s_d.cnt  = nxt_cnt;
                s_d.we_n = !(s_q.wr && (nxt_cnt >= WE_FIRST) && (nxt_cnt < ACT_LAST));
                if (s_q.cnt == ACT_LAST) begin
                    s_d.st   = S_PRE;
                    s_d.cnt  = '0;
                    s_d.ce_n = 1'b1;
                    s_d.we_n = 1'b1;
                    s_d.oe_n = 1'b1;
                    s_d.drv  = 1'b0;
                end
            end
            S_PRE: begin
                s_d.cnt = nxt_cnt;
                if (s_q.cnt == PRE_LAST) begin
                    s_d.st  = S_IDLE;
                    s_d.cnt = '0;
                end
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign ce_n     = s_q.ce_n;
    assign we_n     = s_q.we_n;
    assign oe_n     = s_q.oe_n;
    assign dq_drive = s_q.drv;
endmodule

// File: rtl/fhc_datapath.sv
// Request registers, byte-enable pins and lane-masked read capture.
module fhc_datapath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                cap_en,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_bmask,
    input  logic [DATA_W-1:0]   mem_dq_in,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic [DATA_W/8-1:0] mem_ben_n,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int NB = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [NB-1:0]     ben_n;
        logic [NB-1:0]     sel;
        logic              rdv;
        logic [DATA_W-1:0] rdata;
    } dp_t;

    dp_t d_d, d_q;
    logic [DATA_W-1:0] lane_mask;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_mask[8*i +: 8] = {8{d_q.sel[i]}};
    end

    always_comb begin
        d_d     = d_q;
        d_d.rdv = cap_en;
        if (accept) begin
            d_d.addr  = req_addr;
            d_d.wdata = req_wdata;
            d_d.ben_n = ~req_bmask;
            d_d.sel   = req_bmask;
        end
        if (cap_en) d_d.rdata = mem_dq_in & lane_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q       <= '0;
            d_q.ben_n <= '1;
        end else begin
            d_q <= d_d;
        end
    end

    assign mem_addr   = d_q.addr;
    assign mem_dq_out = d_q.wdata;
    assign mem_ben_n  = d_q.ben_n;
    assign rd_valid   = d_q.rdv;
    assign rd_data    = d_q.rdata;
endmodule

// File: rtl/fram_host_ctrl.sv
module fram_host_ctrl #(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int ACT_CYC = 15,
    parameter int WP_CYC  = 4,
    parameter int PRE_CYC = 15,
    parameter int CYC_CYC = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_bmask,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W/8-1:0] mem_ben_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_drive,
    input  logic [DATA_W-1:0]   mem_dq_in
);
    logic accept;
    logic cap_en;

    fhc_seq #(
        .ACT_CYC(ACT_CYC), .WP_CYC(WP_CYC), .PRE_CYC(PRE_CYC), .CYC_CYC(CYC_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .ready    (req_ready),
        .accept   (accept),
        .cap_en   (cap_en),
        .ce_n     (mem_ce_n),
        .we_n     (mem_we_n),
        .oe_n     (mem_oe_n),
        .dq_drive (mem_dq_drive)
    );

    fhc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cap_en    (cap_en),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_bmask (req_bmask),
        .mem_dq_in (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .mem_ben_n (mem_ben_n),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/fhc_checker.sv
module fhc_checker #(
    parameter int ADDR_W  = 18,
    parameter int NB      = 2,
    parameter int ACT_CYC = 15,
    parameter int PRE_CYC = 15,
    parameter int CYC_CYC = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [NB-1:0]     mem_ben_n,
    input logic              mem_dq_drive
);
    logic        ce_prev_q;
    logic [15:0] lo_run, hi_run, per_run;

    // run-length counters measured from the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_prev_q <= 1'b1;
            lo_run    <= '0;
            hi_run    <= '1;
            per_run   <= '1;
        end else begin
            ce_prev_q <= mem_ce_n;
            if (mem_ce_n) begin
                lo_run <= '0;
                if (hi_run != '1) hi_run <= hi_run + 1'b1;
            end else begin
                hi_run <= '0;
                lo_run <= lo_run + 1'b1;
            end
            if (!mem_ce_n && ce_prev_q) per_run <= 16'd1;
            else if (per_run != '1)     per_run <= per_run + 1'b1;
        end
    end

    a_r3_ce_active: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_n && !ce_prev_q) |-> (lo_run >= 16'(ACT_CYC)));
    a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && ce_prev_q) |-> (hi_run >= 16'(PRE_CYC)));
    a_r6_cycle_time: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && ce_prev_q) |-> (per_run >= 16'(CYC_CYC)));
    a_r8_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_drive);
    a_r5_strobe_inside: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_drive));
    a_r5_we_rise_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_ce_n);
    a_r7_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !ce_prev_q) |-> ($stable(mem_addr) && $stable(mem_ben_n)));
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r3_pulse_in_pre: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mem_ce_n && !ce_prev_q));
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_dq_drive));
endmodule

bind fram_host_ctrl fhc_checker #(
    .ADDR_W(ADDR_W), .NB(DATA_W/8), .ACT_CYC(ACT_CYC), .PRE_CYC(PRE_CYC), .CYC_CYC(CYC_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .mem_addr    (mem_addr),
    .mem_ce_n    (mem_ce_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_ben_n   (mem_ben_n),
    .mem_dq_drive(mem_dq_drive)
);

// File: tb/sim_fram_host_ctrl.sv
`timescale 1ns/1ps
module sim_fram_host_ctrl;
    localparam int ACT = 6, WP = 2, PRE = 3, CYC = 16;
    localparam int EXP_LO  = ACT + 1;   // 7
    localparam int EXP_HI  = 9;         // max(3, 16-6-3)=7, plus idle and setup
    localparam int EXP_PER = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive;
    logic [1:0]  mem_ben_n;
    logic [15:0] mem_dq_out, mem_dq_in;

    always #2.5 clk = ~clk;

    fram_host_ctrl #(
        .ADDR_W(18), .DATA_W(16), .ACT_CYC(ACT), .WP_CYC(WP), .PRE_CYC(PRE), .CYC_CYC(CYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ben_n(mem_ben_n), .mem_dq_out(mem_dq_out),
        .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    // memory model: write on write-enable rise, junk on unselected lanes
    logic [15:0] mem [16];
    always @(posedge mem_we_n or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 16'h0000;
        end else if (!mem_ce_n) begin
            if (!mem_ben_n[0]) mem[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ben_n[1]) mem[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
        end
    end
    assign mem_dq_in = (!mem_oe_n && !mem_ce_n) ?
        {mem_ben_n[1] ? 8'hEE : mem[mem_addr[3:0]][15:8],
         mem_ben_n[0] ? 8'hEE : mem[mem_addr[3:0]][7:0]} : 16'hEEEE;

    // pin monitors
    int  ce_lo = 0, ce_hi = 0, per = 0, we_lo = 0, rv_cnt = 0;
    int  last_ce_lo = 0, last_ce_hi = 0, last_per = 0, last_we_lo = 0;
    bit  seen_fall = 0, we_rise_bad = 0, conflict = 0, pins_moved = 0, rv_bad = 0;
    logic p_ce = 1'b1, p_we = 1'b1, p_rv = 1'b0;
    logic [17:0] p_addr = '0;
    logic [1:0]  p_ben = 2'b11;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n && p_ce) begin
                if (seen_fall) begin last_ce_hi = ce_hi; last_per = per; end
                seen_fall = 1; ce_hi = 0; per = 0;
            end
            if (mem_ce_n && !p_ce) begin last_ce_lo = ce_lo; ce_lo = 0; end
            if (mem_ce_n) ce_hi++; else ce_lo++;
            per++;
            if (mem_we_n && !p_we) begin
                last_we_lo = we_lo; we_lo = 0;
                if (mem_ce_n) we_rise_bad = 1;
            end
            if (!mem_we_n) we_lo++;
            if (!mem_oe_n && mem_dq_drive) conflict = 1;
            if (!mem_ce_n && !p_ce && (mem_addr != p_addr || mem_ben_n != p_ben)) pins_moved = 1;
            if (rd_valid) begin
                rv_cnt++;
                if (!(mem_ce_n && !p_ce) || p_rv) rv_bad = 1;
            end
            p_ce = mem_ce_n; p_we = mem_we_n; p_rv = rd_valid;
            p_addr = mem_addr; p_ben = mem_ben_n;
        end
    end

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // call at a negedge with req_ready high; returns at the negedge where ready returns
    task automatic do_op(input logic wr, input logic [1:0] m, input logic [3:0] a,
                         input logic [15:0] wd, output logic [15:0] rd, output int nv);
        nv = 0; rd = 16'hxxxx;
        req_valid = 1'b1; req_write = wr; req_addr = {14'b0, a};
        req_wdata = wd;   req_bmask = m;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (rd_valid) begin nv++; rd = rd_data; end
            if (req_ready) break;
        end
    endtask

    // {wr, mask, addr, wdata, expected read}
    localparam logic [38:0] VEC [8] = '{
        {1'b1, 2'b11, 4'd1, 16'h1234, 16'h0000},
        {1'b1, 2'b11, 4'd2, 16'hABCD, 16'h0000},
        {1'b0, 2'b11, 4'd1, 16'h0000, 16'h1234},
        {1'b1, 2'b01, 4'd2, 16'h5566, 16'h0000},
        {1'b1, 2'b10, 4'd1, 16'h7788, 16'h0000},
        {1'b0, 2'b11, 4'd2, 16'h0000, 16'hAB66},
        {1'b0, 2'b01, 4'd1, 16'h0000, 16'h0034},
        {1'b0, 2'b10, 4'd2, 16'h0000, 16'hAB00}
    };

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog act=%h exp=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        int          nv;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", {31'b0, req_ready}, 32'd1);
        chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes",
            {29'b0, mem_ce_n, mem_we_n, mem_oe_n}, 32'd7);
        chk(mem_ben_n == 2'b11, "R1 ben", {30'b0, mem_ben_n}, 32'd3);
        chk(!mem_dq_drive && !rd_valid, "R1 drive/valid",
            {30'b0, mem_dq_drive, rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n, "R1 after release", {30'b0, req_ready, mem_ce_n}, 32'd3);

        for (int i = 0; i < 8; i++) begin
            logic        wr;
            logic [1:0]  m;
            int          rv_before;
            wr = VEC[i][38]; m = VEC[i][37:36];
            rv_before = rv_cnt;
            do_op(wr, m, VEC[i][35:32], VEC[i][31:16], rd, nv);
            chk(last_ce_lo == EXP_LO, wr ? "R5 ce low" : "R3 ce low", last_ce_lo, EXP_LO);
            if (i > 0) begin
                chk(last_ce_hi == EXP_HI, "R6 ce high", last_ce_hi, EXP_HI);
                chk(last_per == EXP_PER, "R6 period", last_per, EXP_PER);
            end
            chk(mem_ben_n == ~m, "R4 ben pins", {30'b0, mem_ben_n}, {30'b0, ~m});
            if (wr) begin
                chk(last_we_lo == WP, "R5 we width", last_we_lo, WP);
                chk(nv == 0 && rv_cnt == rv_before, "R9 no pulse on write", nv, 0);
            end else begin
                chk(nv == 1, "R3 one pulse", nv, 1);
                chk(rd == VEC[i][15:0], "R4 read data", {16'b0, rd}, {16'b0, VEC[i][15:0]});
            end
        end

        // R4: empty mask reads zero with both byte enables high
        do_op(1'b0, 2'b00, 4'd1, 16'h0, rd, nv);
        chk(rd == 16'h0000 && nv == 1, "R4 empty mask", {16'b0, rd}, 32'd0);
        chk(mem_ben_n == 2'b11, "R4 empty mask pins", {30'b0, mem_ben_n}, 32'd3);

        // R2: a request raised while busy is ignored
        fork
            begin
                logic [15:0] r1;
                int          n1;
                do_op(1'b0, 2'b11, 4'd1, 16'h0, r1, n1);
                chk(r1 == 16'h7734, "R3 read under stray", {16'b0, r1}, 32'h7734);
            end
            begin
                repeat (3) @(negedge clk);
                chk(req_ready == 1'b0, "R2 busy", {31'b0, req_ready}, 32'd0);
                req_valid = 1'b1; req_write = 1'b1; req_addr = 18'd3;
                req_wdata = 16'hDEAD; req_bmask = 2'b11;
                repeat (2) @(negedge clk);
                req_valid = 1'b0;
            end
        join
        do_op(1'b0, 2'b11, 4'd3, 16'h0, rd, nv);
        chk(rd == 16'h0000, "R2 stray ignored", {16'b0, rd}, 32'd0);

        repeat (3) @(negedge clk);
        chk(!we_rise_bad, "R5 we rises under ce", {31'b0, we_rise_bad}, 32'd0);
        chk(!conflict, "R8 oe vs drive", {31'b0, conflict}, 32'd0);
        chk(!pins_moved, "R7 pins stable", {31'b0, pins_moved}, 32'd0);
        chk(!rv_bad, "R3 pulse timing", {31'b0, rv_bad}, 32'd0);
        finish_run();
    end
endmodule